// File: doc/BRIEF.md
# PCI configuration address generator

This block sits on the host side of a PCI bus and builds the 32-bit value placed on the AD lines during the address phase of a configuration cycle. A requester gives a one-cycle strobe together with the target bus, device, function and dword index, and a flag that picks read or write. One clock later the block presents the formatted address word and the matching configuration command code, and marks the result with a one-cycle done pulse.

When the target sits on the local bus (bus number 0), the block emits the local format: the two low bits are 00, and a single device-select line is raised in the upper part of the word, chosen by the device number. For any other bus it emits the forwarded format: the two low bits are 01, and bus, device, function and dword index are packed as fields, with the top byte cleared. A local device number that has no select line gives an error pulse and no new address. A request that arrives while a result is being presented is refused; busy tells the requester when that is so.

Top module: `cfg_addr_gen`

## Requirements
- R1: A request whose bus number is 0 produces an address word whose bits [1:0] are 2'b00.
- R2: In a bus-0 address, bits [10:8] hold the function number and bits [7:2] hold the dword index.
- R3: In a bus-0 address, exactly one of bits [31:11] is 1, namely bit 11+D for device number D (0 to 20).
- R4: A request whose bus number is not 0 produces an address word whose bits [1:0] are 2'b01.
- R5: In a non-zero-bus address, bits [23:16] hold the bus number, bits [15:11] the device number, bits [10:8] the function and bits [7:2] the dword index.
- R6: In a non-zero-bus address, bits [31:24] are 0.
- R7: A bus-0 request with device number above 20 raises err_o for exactly one cycle, leaves done_o low, and leaves ad_o and cmd_o at their previous values.
- R8: cmd_o is 4'b1010 for a read (wr_i = 0) and 4'b1011 for a write (wr_i = 1).
- R9: An accepted request at a clock edge sets ad_o, cmd_o and a done_o pulse of exactly one cycle right after that edge; ad_o and cmd_o then hold until the next accepted valid request.
- R10: busy_o is 1 in the cycle after an accepted request (done or error); a request strobe sampled while busy_o is 1 is ignored and changes no output.
- R11: After reset, ad_o is 0, cmd_o is 0, and done_o, err_o and busy_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| wr_i | input | 1 | 1 = configuration write, 0 = read |
| bus_i | input | 8 | Target bus number |
| dev_i | input | 5 | Target device number |
| fn_i | input | 3 | Target function number |
| dw_i | input | 6 | Configuration dword index |
| ad_o | output | 32 | Registered address-phase word |
| cmd_o | output | 4 | Registered command code |
| done_o | output | 1 | One-cycle pulse: new address valid |
| err_o | output | 1 | One-cycle pulse: local device number out of range |
| busy_o | output | 1 | Result being presented; new strobes ignored |

## Verification
The bench drives the edge of the select range, devices 0 and 20 on bus 0, where an off-by-one in the select shift would raise the wrong line or fall off the word, and device 21, where a missing range check would emit an address with no select line or with a stray bit. It switches between bus 0 and bus 1 and 255 with all-ones fields, so a design that chose the format from the wrong bits, or let fields overlap or spill into the top byte, would show wrong low bits or a non-zero reserved byte. It holds the strobe high across two cycles with changed fields, so a design that accepted while busy would emit a second done or overwrite the held address, and it checks that an error request leaves the earlier address and command in place.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {
    FMT_LOCAL  = 2'b00,
    FMT_REMOTE = 2'b01
  } fmt_e;
endpackage

// File: rtl/cfg_type0_enc.sv
module cfg_type0_enc #(
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int DW_W  = 6,
  parameter int AD_W  = 32
) (
  input  logic [DEV_W-1:0] dev_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [DW_W-1:0]  dw_i,
  output logic [AD_W-1:0]  ad_o,
  output logic             range_err_o
);
  import cfg_addr_pkg::*;

  localparam int SEL_LO = FN_W + DW_W + 2;
  localparam int SEL_N  = AD_W - SEL_LO;

  logic [SEL_N-1:0] sel;

  // One select line per reachable device number.
  genvar g;
  generate
    for (g = 0; g < SEL_N; g++) begin : g_sel
      assign sel[g] = (int'(dev_i) == g);
    end
  endgenerate

  assign range_err_o = (int'(dev_i) >= SEL_N);
  assign ad_o        = {sel, fn_i, dw_i, FMT_LOCAL};
endmodule

// File: rtl/cfg_type1_enc.sv
module cfg_type1_enc #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int DW_W  = 6,
  parameter int AD_W  = 32
) (
  input  logic [BUS_W-1:0] bus_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [DW_W-1:0]  dw_i,
  output logic [AD_W-1:0]  ad_o
);
  import cfg_addr_pkg::*;

  localparam int RSV_W = AD_W - BUS_W - DEV_W - FN_W - DW_W - 2;

  assign ad_o = {{RSV_W{1'b0}}, bus_i, dev_i, fn_i, dw_i, FMT_REMOTE};
endmodule

// File: rtl/cfg_req_ctrl.sv
module cfg_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic bad_i,
  output logic load_o,
  output logic done_o,
  output logic err_o,
  output logic busy_o
);
  logic done_q, err_q;
  logic done_d, err_d;
  logic accept;

  always_comb begin
    accept = req_i & ~busy_o;
    done_d = accept & ~bad_i;
    err_d  = accept &  bad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign load_o = done_d;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign busy_o = done_q | err_q;
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int DW_W  = 6,
  parameter int AD_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [DW_W-1:0]  dw_i,
  output logic [AD_W-1:0]  ad_o,
  output logic [3:0]       cmd_o,
  output logic             done_o,
  output logic             err_o,
  output logic             busy_o
);
  import cfg_addr_pkg::*;

  logic [AD_W-1:0] ad_local, ad_remote, ad_d, ad_nxt, ad_q;
  logic [3:0]      cmd_d, cmd_nxt, cmd_q;
  logic            is_local, range_err, bad, load;

  cfg_type0_enc #(.DEV_W(DEV_W), .FN_W(FN_W), .DW_W(DW_W), .AD_W(AD_W)) u_t0 (
    .dev_i       (dev_i),
    .fn_i        (fn_i),
    .dw_i        (dw_i),
    .ad_o        (ad_local),
    .range_err_o (range_err)
  );

  cfg_type1_enc #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .DW_W(DW_W), .AD_W(AD_W)) u_t1 (
    .bus_i (bus_i),
    .dev_i (dev_i),
    .fn_i  (fn_i),
    .dw_i  (dw_i),
    .ad_o  (ad_remote)
  );

  cfg_req_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .bad_i  (bad),
    .load_o (load),
    .done_o (done_o),
    .err_o  (err_o),
    .busy_o (busy_o)
  );

  // Next-state: pick the format, then hold unless a valid request loads.
  always_comb begin
    is_local = (bus_i == '0);
    bad      = is_local & range_err;
    ad_d     = is_local ? ad_local : ad_remote;
    cmd_d    = wr_i ? CMD_CFG_WR : CMD_CFG_RD;
    ad_nxt   = load ? ad_d  : ad_q;
    cmd_nxt  = load ? cmd_d : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q  <= '0;
      cmd_q <= '0;
    end else begin
      ad_q  <= ad_nxt;
      cmd_q <= cmd_nxt;
    end
  end

  assign ad_o  = ad_q;
  assign cmd_o = cmd_q;
endmodule

// File: rtl/cfg_addr_gen_chk.sv
module cfg_addr_gen_chk #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int DW_W  = 6,
  parameter int AD_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             wr_i,
  input logic [BUS_W-1:0] bus_i,
  input logic [DEV_W-1:0] dev_i,
  input logic [FN_W-1:0]  fn_i,
  input logic [DW_W-1:0]  dw_i,
  input logic [AD_W-1:0]  ad_o,
  input logic [3:0]       cmd_o,
  input logic             done_o,
  input logic             err_o,
  input logic             busy_o
);
  localparam int SEL_LO = FN_W + DW_W + 2;
  localparam int SEL_N  = AD_W - SEL_LO;
  localparam int RSV_LO = SEL_LO + DEV_W + BUS_W;

  p_local_fmt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ($past(bus_i) == '0) |-> ad_o[1:0] == 2'b00);

  p_remote_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ($past(bus_i) != '0) |-> ad_o[1:0] == 2'b01);

  p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ($past(bus_i) == '0) |->
      ad_o[AD_W-1:SEL_LO] == ({{(SEL_N-1){1'b0}}, 1'b1} << $past(dev_i)));

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ($past(bus_i) != '0) |-> ad_o[AD_W-1:RSV_LO] == '0);

  p_cmd_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cmd_o == ($past(wr_i) ? 4'b1011 : 4'b1010));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o) |=> (done_o || err_o));

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !done_o && $stable(ad_o) && $stable(cmd_o));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !done_o && !err_o && $stable(ad_o));
endmodule

bind cfg_addr_gen cfg_addr_gen_chk #(
  .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .DW_W(DW_W), .AD_W(AD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .bus_i(bus_i),
  .dev_i(dev_i), .fn_i(fn_i), .dw_i(dw_i), .ad_o(ad_o), .cmd_o(cmd_o),
  .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
);

// File: tb/tb_cfg_addr_gen.sv
`timescale 1ns/1ps
module tb_cfg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, wr_i;
  logic [7:0]  bus_i;
  logic [4:0]  dev_i;
  logic [2:0]  fn_i;
  logic [5:0]  dw_i;
  logic [31:0] ad_o;
  logic [3:0]  cmd_o;
  logic        done_o, err_o, busy_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  cfg_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .bus_i(bus_i),
    .dev_i(dev_i), .fn_i(fn_i), .dw_i(dw_i), .ad_o(ad_o), .cmd_o(cmd_o),
    .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_local(input int dev, input logic [2:0] fn, input logic [5:0] dw);
    logic [31:0] e = '0;
    e[11 + dev] = 1'b1;
    e[10:8] = fn;
    e[7:2]  = dw;
    return e;
  endfunction

  function automatic logic [31:0] exp_remote(input logic [7:0] b, input logic [4:0] d, input logic [2:0] fn, input logic [5:0] dw);
    return {8'h00, b, d, fn, dw, 2'b01};
  endfunction

  // Strobe for one cycle; after the return the edge has passed and the
  // bench sits at the negedge of the presentation cycle.
  task automatic issue(input logic [7:0] b, input logic [4:0] d, input logic [2:0] fn, input logic [5:0] dw, input logic w);
    @(negedge clk);
    bus_i = b; dev_i = d; fn_i = fn; dw_i = dw; wr_i = w; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(ad_o == 32'h0, "R11 ad", ad_o, 32'h0);
    chk(cmd_o == 4'h0, "R11 cmd", {28'h0, cmd_o}, 32'h0);
    chk({done_o, err_o, busy_o} == 3'b000, "R11 flags", {29'h0, done_o, err_o, busy_o}, 32'h0);
  endtask

  task automatic t_local(input int d, input logic [2:0] fn, input logic [5:0] dw, input logic w);
    logic [31:0] e;
    e = exp_local(d, fn, dw);
    issue(8'h00, 5'(d), fn, dw, w);
    chk(done_o && !err_o, "R9 done", {30'h0, done_o, err_o}, 32'h2);
    chk(ad_o[1:0] == 2'b00, "R1 low bits", {30'h0, ad_o[1:0]}, 32'h0);
    chk(ad_o[10:0] == e[10:0], "R2 fields", ad_o, e);
    chk(ad_o[31:11] == e[31:11] && $countones(ad_o[31:11]) == 1, "R3 select", ad_o, e);
    chk(cmd_o == (w ? 4'b1011 : 4'b1010), "R8 cmd", {28'h0, cmd_o}, {28'h0, (w ? 4'b1011 : 4'b1010)});
    chk(busy_o, "R10 busy", {31'h0, busy_o}, 32'h1);
    @(negedge clk);
    chk(!done_o && ad_o == e, "R9 pulse/hold", ad_o, e);
  endtask

  task automatic t_remote(input logic [7:0] b, input logic [4:0] d, input logic [2:0] fn, input logic [5:0] dw, input logic w);
    logic [31:0] e;
    e = exp_remote(b, d, fn, dw);
    issue(b, d, fn, dw, w);
    chk(done_o, "R9 done", {31'h0, done_o}, 32'h1);
    chk(ad_o[1:0] == 2'b01, "R4 low bits", {30'h0, ad_o[1:0]}, 32'h1);
    chk(ad_o[23:2] == e[23:2], "R5 fields", ad_o, e);
    chk(ad_o[31:24] == 8'h00, "R6 reserved", ad_o, e);
    chk(cmd_o == (w ? 4'b1011 : 4'b1010), "R8 cmd", {28'h0, cmd_o}, {28'h0, (w ? 4'b1011 : 4'b1010)});
    @(negedge clk);
  endtask

  task automatic t_error;
    logic [31:0] e;
    e = exp_remote(8'h05, 5'd3, 3'd1, 6'd9);
    issue(8'h05, 5'd3, 3'd1, 6'd9, 1'b1);
    @(negedge clk);
    issue(8'h00, 5'd21, 3'd2, 6'd4, 1'b0);
    chk(err_o && !done_o, "R7 err pulse", {30'h0, err_o, done_o}, 32'h2);
    chk(ad_o == e, "R7 ad held", ad_o, e);
    chk(cmd_o == 4'b1011, "R7 cmd held", {28'h0, cmd_o}, 32'hB);
    chk(busy_o, "R10 busy on err", {31'h0, busy_o}, 32'h1);
    @(negedge clk);
    chk(!err_o && ad_o == e, "R7 single cycle", {31'h0, err_o}, 32'h0);
    issue(8'h00, 5'd31, 3'd0, 6'd0, 1'b0);
    chk(err_o && !done_o && ad_o == e, "R7 dev 31", ad_o, e);
    @(negedge clk);
  endtask

  task automatic t_busy;
    logic [31:0] e;
    e = exp_local(4, 3'd3, 6'd17);
    @(negedge clk);
    bus_i = 8'h00; dev_i = 5'd4; fn_i = 3'd3; dw_i = 6'd17; wr_i = 1'b0; req_i = 1'b1;
    @(negedge clk);
    chk(done_o && busy_o && ad_o == e, "R10 first accepted", ad_o, e);
    bus_i = 8'h07; dev_i = 5'd9; wr_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(!done_o && !err_o, "R10 busy ignores", {30'h0, done_o, err_o}, 32'h0);
    chk(ad_o == e && cmd_o == 4'b1010, "R10 output kept", ad_o, e);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_i = 1'b0; wr_i = 1'b0;
    bus_i = '0; dev_i = '0; fn_i = '0; dw_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_local(0, 3'd0, 6'd0, 1'b0);
    t_local(20, 3'd7, 6'd63, 1'b1);
    t_local(11, 3'd5, 6'd42, 1'b0);
    t_remote(8'h01, 5'd0, 3'd0, 6'd0, 1'b1);
    t_remote(8'hFF, 5'd31, 3'd7, 6'd63, 1'b0);
    t_remote(8'h3C, 5'd18, 3'd2, 6'd21, 1'b1);
    t_error();
    t_busy();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule